// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

A 16-bit accumulator driven by one asynchronous input pin. In event mode it counts active edges on the pin, and the edge polarity can be selected. In gated mode it counts ticks of a divide-by-64 prescaler for as long as the pin is at its active level. The pin passes through a two-flop synchronizer before edge detection, so each level must be held for more than two module clocks to be counted reliably.

Software configures the block and reads it over a small register bus. A control register holds the enables, mode and polarity. A flag register holds an input flag and an overflow flag, both cleared by writing 1. The count register can be read, and it can be loaded with any value. An interrupt request is raised when a flag is set and its enable bit is also set. Gated mode depends on the main timer being enabled (`tmr_en_i`), but event mode keeps counting without it.

Top module: `pacc_top`

## Requirements
- R1: After reset, reads at address 0 (control), 1 (flags) and 2 (count) all return 0, and `in_flag_o`, `ovf_flag_o` and `irq_o` are low.
- R2: With control bit 0 (enable) = 1 and bit 1 (mode) = 0, the count goes up by one for each active pin edge. Bit 2 (polarity) = 0 makes rising edges active and 1 makes falling edges active. Edges of the other polarity are ignored. The count changes on the third rising clock edge after the pin changes.
- R3: In event mode, each active edge sets the input flag (flag register bit 0).
- R4: In gated mode (bit 1 = 1), while the pin is at its active level, the count goes up by one every 64 module clocks. The first increment comes 64 clocks after the control write. The active level is high when polarity = 0 and low when polarity = 1. While the pin is inactive, the count does not change.
- R5: In gated mode, the input flag is set on the trailing edge of the gate: falling when polarity = 0, rising when polarity = 1. It is not set on the leading edge.
- R6: An increment from 0xFFFF gives 0x0000 and sets the overflow flag (flag register bit 1).
- R7: `irq_o` is high when (input flag AND control bit 3) OR (overflow flag AND control bit 4), and low otherwise.
- R8: Writing 1 to a flag bit at address 1 clears that flag. Writing 0 leaves it unchanged. A set in the same cycle wins over the clear.
- R9: With the enable bit clear, the count does not change and no flag is set, whatever the pin does.
- R10: When `tmr_en_i` is low, gated counting stops, but event counting continues.
- R11: A write to address 2 loads the count. A load wins over an increment in the same cycle.
- R12: The control register reads back the written value in bits 4:0. The flag register reads back the overflow flag in bit 1 and the input flag in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous accumulator input |
| tmr_en_i | input | 1 | Main timer enable; gates the prescaler |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 flags, 2 count |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| in_flag_o | output | 1 | Input flag |
| ovf_flag_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A synchronizer that is too shallow or too deep moves the count update away from the third clock edge after a pin change. The check that samples one edge early and at the edge itself exposes this at once. A prescaler with the wrong period, or one not restarted when gated mode is entered, shows as a wrong count at the 63rd or 64th clock after the control write. A wrong polarity decode shows on the first pulse, as a count that is missing or doubled. A lost wrap or flag-priority fault shows on the flag outputs in the cycle after the offending edge.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;

  typedef struct packed {
    logic ovf_ie;
    logic in_ie;
    logic pol;
    logic gated;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/pacc_sync_edge.sv
module pacc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o  = sync_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
  parameter int DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int DIV_W = $clog2(DIV);
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

  logic [DIV_W-1:0] div_q;

  // restart from zero whenever the prescaler is idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         div_q <= '0;
    else if (!run_i)     div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                 div_q <= div_q + 1'b1;
  end

  assign tick_o = run_i && (div_q == LAST);
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = inc_i && !load_i && (&cnt_q);
endmodule

// File: rtl/pacc_top.sv
module pacc_top
  import pacc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV         = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             tmr_en_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             in_flag_o,
  output logic             ovf_flag_o,
  output logic             irq_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic             in_q, ovf_q;
  logic             lvl, rise, fall;
  logic             tick, run;
  logic             act_edge, gate_on, trail;
  logic             inc, in_set, wrap, load;
  logic [CNT_W-1:0] cnt;
  logic             wr_ctrl, wr_flag;

  pacc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .lvl_o (lvl),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign run = ctrl_q.en && ctrl_q.gated && tmr_en_i;

  pacc_prescale #(.DIV(DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  assign act_edge = ctrl_q.pol ? fall : rise;
  assign gate_on  = ctrl_q.pol ? ~lvl : lvl;
  assign trail    = ctrl_q.pol ? rise : fall;

  assign inc    = ctrl_q.en && (ctrl_q.gated ? (tick && gate_on) : act_edge);
  assign in_set = ctrl_q.en && (ctrl_q.gated ? trail : act_edge);

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
  assign wr_flag = wr_en_i && (addr_i == ADDR_FLAG);
  assign load    = wr_en_i && (addr_i == ADDR_CNT);

  pacc_counter #(.W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(wdata_i),
    .inc_i     (inc),
    .cnt_o     (cnt),
    .wrap_o    (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  // set wins over write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      in_q  <= in_set | (in_q  & ~(wr_flag & wdata_i[0]));
      ovf_q <= wrap   | (ovf_q & ~(wr_flag & wdata_i[1]));
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = CNT_W'(ctrl_q);
      ADDR_FLAG: rdata_o = CNT_W'({ovf_q, in_q});
      ADDR_CNT:  rdata_o = cnt;
      default:   rdata_o = '0;
    endcase
  end

  assign in_flag_o  = in_q;
  assign ovf_flag_o = ovf_q;
  assign irq_o      = (in_q & ctrl_q.in_ie) | (ovf_q & ctrl_q.ovf_ie);
endmodule

// File: rtl/pacc_top_chk.sv
module pacc_top_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       addr_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic             tmr_en_i,
  input logic [CNT_W-1:0] cnt,
  input logic             inc,
  input logic             in_set,
  input logic             acc_en,
  input logic             gated,
  input logic             in_flag,
  input logic             ovf_flag,
  input logic             irq
);
  logic ld;
  assign ld = wr_en_i && (addr_i == 2'd2);

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  p_ovf_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && !ld && (&cnt)) |=> (cnt == '0 && ovf_flag));

  p_irq_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq |-> (in_flag || ovf_flag));

  p_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1 && wdata_i[0] && !in_set) |=> !in_flag);

  p_disabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_en && !ld) |=> $stable(cnt));

  p_tmr_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gated && !tmr_en_i && !ld) |=> $stable(cnt));

  p_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> (cnt == $past(wdata_i)));
endmodule

bind pacc_top pacc_top_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .tmr_en_i(tmr_en_i),
  .cnt     (cnt),
  .inc     (inc),
  .in_set  (in_set),
  .acc_en  (ctrl_q.en),
  .gated   (ctrl_q.gated),
  .in_flag (in_q),
  .ovf_flag(ovf_q),
  .irq     (irq_o)
);

// File: tb/pacc_top_tb.sv
module pacc_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin_i = 1'b0;
  logic        tmr_en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        in_flag_o, ovf_flag_o, irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk_i = ~clk_i;

  pacc_top u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .tmr_en_i(tmr_en_i),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .in_flag_o(in_flag_o), .ovf_flag_o(ovf_flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  task automatic pulse(input logic act);
    @(negedge clk_i); pin_i = act;  settle();
    pin_i = ~act; settle();
  endtask

  // ctrl bits: 0 en, 1 gated, 2 pol, 3 in_ie, 4 ovf_ie
  task automatic setup(input logic [15:0] ctrl, input logic idle);
    wr(2'd0, 16'h0);
    pin_i = idle; settle();
    wr(2'd2, 16'h0);
    wr(2'd1, 16'h3);
    wr(2'd0, ctrl);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int a = 0; a < 3; a++) begin
      rd(a[1:0], v); chk("R1 reset reg", v, 16'h0);
    end
    chk("R1 flags/irq", {13'h0, in_flag_o, ovf_flag_o, irq_o}, 16'h0);

    // R12 control readback
    wr(2'd0, 16'h001A); rd(2'd0, v); chk("R12 ctrl readback", v, 16'h001A);

    // R2/R3/R10 event sweep, timer disabled
    tmr_en_i = 1'b0;
    for (int p = 0; p < 2; p++) begin
      for (int n = 1; n <= 17; n += 4) begin
        setup(16'h1 | (p[0] ? 16'h4 : 16'h0), p[0]);
        for (int i = 0; i < n; i++) pulse(~p[0]);
        rd(2'd2, v); chk($sformatf("R2 R10 event pol=%0d n=%0d", p, n), v, 16'(n));
        chk("R3 input flag", {15'h0, in_flag_o}, 16'h1);
      end
    end

    // R2 latency and ignored polarity (pol=0)
    setup(16'h1, 1'b0);
    @(negedge clk_i); pin_i = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    rd(2'd2, v); chk("R2 no change at 2nd edge", v, 16'h0);
    @(negedge clk_i);
    rd(2'd2, v); chk("R2 change at 3rd edge", v, 16'h1);
    settle(); pin_i = 1'b0; settle();
    rd(2'd2, v); chk("R2 falling ignored", v, 16'h1);

    // R8 write 0 keeps, write 1 clears
    wr(2'd1, 16'h0); rd(2'd1, v); chk("R8 write0 keeps", v, 16'h1);
    wr(2'd1, 16'h1); rd(2'd1, v); chk("R8 write1 clears", v, 16'h0);

    // R7 irq from input flag
    setup(16'h9, 1'b0);
    chk("R7 irq low", {15'h0, irq_o}, 16'h0);
    pulse(1'b1);
    chk("R7 irq input", {15'h0, irq_o}, 16'h1);
    wr(2'd1, 16'h1);
    chk("R7 irq cleared", {15'h0, irq_o}, 16'h0);

    // R6 overflow wrap
    setup(16'h11, 1'b0);
    wr(2'd2, 16'hFFFE);
    pulse(1'b1);
    rd(2'd2, v); chk("R6 to FFFF", v, 16'hFFFF);
    chk("R6 no ovf yet", {15'h0, ovf_flag_o}, 16'h0);
    pulse(1'b1);
    rd(2'd2, v); chk("R6 wrapped", v, 16'h0);
    chk("R6 ovf flag", {15'h0, ovf_flag_o}, 16'h1);
    chk("R7 irq ovf", {15'h0, irq_o}, 16'h1);
    wr(2'd1, 16'h2);
    chk("R8 ovf cleared", {15'h0, ovf_flag_o}, 16'h0);

    // R11 load wins over same-cycle increment
    setup(16'h1, 1'b0);
    @(negedge clk_i); pin_i = 1'b1;
    @(negedge clk_i);
    wr(2'd2, 16'h1234);
    settle();
    rd(2'd2, v); chk("R11 load wins", v, 16'h1234);
    pin_i = 1'b0; settle();

    // R9 disabled
    setup(16'h0, 1'b0);
    wr(2'd2, 16'h0042);
    for (int i = 0; i < 3; i++) pulse(1'b1);
    rd(2'd2, v); chk("R9 count held", v, 16'h0042);
    chk("R9 no flag", {15'h0, in_flag_o}, 16'h0);

    // R10 gated blocked without timer
    tmr_en_i = 1'b0;
    setup(16'h3, 1'b1);
    repeat (200) @(negedge clk_i);
    rd(2'd2, v); chk("R10 gated stopped", v, 16'h0);

    // R4/R5 gated, exact 64-clock steps
    tmr_en_i = 1'b1;
    for (int p = 0; p < 2; p++) begin
      wr(2'd0, 16'h0);
      pin_i = ~p[0]; settle();
      wr(2'd2, 16'h0);
      wr(2'd1, 16'h3);
      wr(2'd0, 16'h3 | (p[0] ? 16'h4 : 16'h0));
      for (int k = 1; k <= 3; k++) begin
        repeat (63) @(negedge clk_i);
        rd(2'd2, v); chk($sformatf("R4 pol=%0d before tick %0d", p, k), v, 16'(k - 1));
        @(negedge clk_i);
        rd(2'd2, v); chk($sformatf("R4 pol=%0d at tick %0d", p, k), v, 16'(k));
      end
      chk("R5 no flag on lead", {15'h0, in_flag_o}, 16'h0);
      pin_i = p[0]; settle();
      chk("R5 flag on trail", {15'h0, in_flag_o}, 16'h1);
      rd(2'd2, v0);
      repeat (200) @(negedge clk_i);
      rd(2'd2, v); chk("R4 inactive hold", v, v0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule